// File: doc/BRIEF.md
# Pulse-Swallow Frequency Divider

This block divides a fast input clock by a programmable total ratio of P·N + A. It uses three parts. The first is a dual-modulus prescaler that counts either P or P+1 input clocks per period. The second is a swallow counter loaded with A. The third is a main counter loaded with N. For the first A prescaler periods of each output cycle the prescaler runs at P+1. For the remaining N−A periods it runs at P. When the main counter expires, the block emits one divided pulse. The prescaler is modelled as a synchronous counter on the same clock as the rest of the block.

Software-style settings arrive on a load strobe, together with a modulus-select bit, the swallow value A and the main value N. The first load after reset, or the first load after a fault, starts the divider at once. A load while the divider runs is held back and applied at the next output-cycle boundary, so every output cycle uses a single ratio. If the settings in force are illegal (N below the minimum, or A not below N), the block parks in a fault state, raises an error flag and produces no pulses until a valid load arrives.

The controller is a four-state machine:
- `ST_IDLE`: the state after reset, waiting for a first load.
- `ST_SWALLOW`: the prescaler counts P+1 while the swallow count is nonzero.
- `ST_MAIN`: the prescaler counts P.
- `ST_FAULT`: the settings in force are illegal.

The transitions are:
- Start: from `ST_IDLE` or `ST_FAULT` on a load.
- Swallow-done: from `ST_SWALLOW` to `ST_MAIN` when the swallow count expires.
- Boundary: from a running state when the main count expires. It goes to `ST_SWALLOW` or `ST_MAIN` depending on whether the next A is nonzero, or to `ST_FAULT` if the next settings are illegal.
- Reject: from `ST_IDLE` or `ST_FAULT` to `ST_FAULT` when the loaded values are illegal.

Top module: `swallow_divider`

## Requirements
- R1: After reset, `fp`, `mod_ctl` and `cfg_err` are 0. No `fp` pulse appears until a load is given.
- R2: With `mod_sel`=1, the prescaler modulus P is P_SMALL (default 64). The distance between consecutive `fp` pulses, and from a starting load edge to the first `fp`, is P·N+A input clocks.
- R3: With `mod_sel`=0, P is P_LARGE (default 128). The output period is P·N+A input clocks.
- R4: In each output cycle, `mod_ctl` is high for exactly A·(P+1) input clocks, counted from the cycle's start, and low for the rest. With A=0 it stays low.
- R5: `fp` is high for exactly one input clock per output cycle.
- R6: A load while running does not change the output cycle in progress. The new settings govern the cycles after the next boundary.
- R7: When the settings in force have N < N_MIN (default 16), `cfg_err` is 1, and `fp` and `mod_ctl` stay 0.
- R8: When the settings in force have A ≥ N, `cfg_err` is 1 and `fp` stays 0. A running divider enters this state at the boundary where such settings take over. The cycle that ends at that boundary still produces its `fp`.
- R9: In the fault state, a load of legal values clears `cfg_err` and restarts the divider at once. The first `fp` follows P·N+A clocks after the load edge.
- R10: When several loads occur within one output cycle, only the last one takes effect at the boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Active-low synchronous reset |
| mod_sel | input | 1 | Modulus select: 1 gives P_SMALL, 0 gives P_LARGE |
| swallow_a | input | A_W | Swallow value A |
| main_n | input | N_W | Main counter value N |
| load | input | 1 | Strobe that captures mod_sel, swallow_a and main_n |
| fp | output | 1 | Divided output pulse, one clock wide |
| mod_ctl | output | 1 | Prescaler modulus control: 1 selects P+1 |
| cfg_err | output | 1 | Settings in force are illegal |

## Verification
The bench builds the divider with P_SMALL=4, P_LARGE=8, A_W=3, N_W=5 and N_MIN=4. With these values each output cycle lasts tens of clocks instead of thousands. In a short run the bench can therefore cover both moduli, A=0, the largest A and N, settings changes in mid-cycle, repeated loads, and both fault causes together with recovery. The scoreboard predicts each output period and the number of clocks `mod_ctl` is high from P·N+A and A·(P+1). It compares these against every observed `fp` interval.

// File: rtl/swallow_div_pkg.sv
package swallow_div_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SWALLOW = 2'd1,
        ST_MAIN    = 2'd2,
        ST_FAULT   = 2'd3
    } div_state_t;

endpackage

// File: rtl/dm_prescaler.sv
module dm_prescaler #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [CW-1:0] modulus,
    output logic          wrap
);
    logic [CW-1:0] cnt_q;

    assign wrap = (cnt_q == modulus - CW'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr || wrap) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    // R2: the phase count never runs past the selected modulus
    a_r2_phase_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < modulus);

endmodule

// File: rtl/dn_counter.sv
module dn_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         dec,
    output logic [W-1:0] cnt,
    output logic         is_one
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (ld) begin
            cnt <= ld_val;
        end else if (dec) begin
            cnt <= cnt - W'(1);
        end
    end

    assign is_one = (cnt == W'(1));

    // R6: a counter moves only on a reload or a decrement
    a_r6_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !dec) |=> $stable(cnt));

    // R4: a decrement never wraps through zero
    a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !ld) |-> (cnt != '0));

endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
    import swallow_div_pkg::*;
#(
    parameter int P_SMALL = 64,
    parameter int P_LARGE = 128,
    parameter int A_W     = 7,
    parameter int N_W     = 11,
    parameter int N_MIN   = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mod_sel,
    input  logic [A_W-1:0] swallow_a,
    input  logic [N_W-1:0] main_n,
    input  logic           load,
    output logic           fp,
    output logic           mod_ctl,
    output logic           cfg_err
);
    localparam int CW = $clog2(P_LARGE + 2);
    localparam logic [CW-1:0] PS = CW'(P_SMALL);
    localparam logic [CW-1:0] PL = CW'(P_LARGE);
    localparam logic [N_W-1:0] NLO = N_W'(N_MIN);

    div_state_t     state_q, state_d;
    logic           act_sel_q;
    logic [A_W-1:0] act_a_q, pend_a_q, nxt_a;
    logic [N_W-1:0] act_n_q, pend_n_q, nxt_n;
    logic           pend_sel_q, pend_vld_q, nxt_sel;
    logic           fp_q;

    logic           running, pre_wrap, boundary, start, reload;
    logic [A_W-1:0] sw_cnt, rl_a;
    logic [N_W-1:0] mn_cnt, rl_n;
    logic           sw_one, mn_one;
    logic [CW-1:0]  modulus;

    function automatic logic cfg_ok(input logic [A_W-1:0] a, input logic [N_W-1:0] n);
        return (n >= NLO) && (N_W'(a) < n);
    endfunction

    assign running  = (state_q == ST_SWALLOW) || (state_q == ST_MAIN);
    assign boundary = running && pre_wrap && mn_one;
    assign start    = !running && load;

    // settings applied at the next boundary
    assign nxt_a   = pend_vld_q ? pend_a_q   : act_a_q;
    assign nxt_n   = pend_vld_q ? pend_n_q   : act_n_q;
    assign nxt_sel = pend_vld_q ? pend_sel_q : act_sel_q;

    // reload values: inputs on a start, queued settings on a boundary
    assign rl_a   = start ? swallow_a : nxt_a;
    assign rl_n   = start ? main_n    : nxt_n;
    assign reload = start || boundary;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_FAULT: begin
                if (load) begin
                    if (!cfg_ok(swallow_a, main_n))  state_d = ST_FAULT;
                    else if (swallow_a != '0)        state_d = ST_SWALLOW;
                    else                             state_d = ST_MAIN;
                end
            end
            ST_SWALLOW, ST_MAIN: begin
                if (boundary) begin
                    if (!cfg_ok(nxt_a, nxt_n))       state_d = ST_FAULT;
                    else if (nxt_a != '0)            state_d = ST_SWALLOW;
                    else                             state_d = ST_MAIN;
                end else if (state_q == ST_SWALLOW && pre_wrap && sw_one) begin
                    state_d = ST_MAIN;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // settings registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_sel_q  <= 1'b0;
            act_a_q    <= '0;
            act_n_q    <= '0;
            pend_sel_q <= 1'b0;
            pend_a_q   <= '0;
            pend_n_q   <= '0;
            pend_vld_q <= 1'b0;
            fp_q       <= 1'b0;
        end else begin
            fp_q <= boundary;
            if (start) begin
                act_sel_q  <= mod_sel;
                act_a_q    <= swallow_a;
                act_n_q    <= main_n;
                pend_vld_q <= 1'b0;
            end else if (boundary) begin
                act_sel_q  <= nxt_sel;
                act_a_q    <= nxt_a;
                act_n_q    <= nxt_n;
                pend_vld_q <= 1'b0;
            end
            if (running && load) begin
                pend_sel_q <= mod_sel;
                pend_a_q   <= swallow_a;
                pend_n_q   <= main_n;
                pend_vld_q <= 1'b1;
            end
        end
    end

    // modulus seen by the prescaler; on a start the selection comes from the input
    always_comb begin
        logic sel_now;
        sel_now = start ? mod_sel : act_sel_q;
        modulus = sel_now ? PS : PL;
        if (state_q == ST_SWALLOW) modulus = modulus + CW'(1);
    end

    dm_prescaler #(.CW(CW)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (!running || boundary),
        .modulus (modulus),
        .wrap    (pre_wrap)
    );

    dn_counter #(.W(A_W)) u_swallow (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (reload),
        .ld_val (rl_a),
        .dec    (pre_wrap && state_q == ST_SWALLOW),
        .cnt    (sw_cnt),
        .is_one (sw_one)
    );

    dn_counter #(.W(N_W)) u_main (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (reload),
        .ld_val (rl_n),
        .dec    (pre_wrap && running && !boundary),
        .cnt    (mn_cnt),
        .is_one (mn_one)
    );

    // output decode
    always_comb begin
        fp      = fp_q;
        mod_ctl = 1'b0;
        cfg_err = 1'b0;
        unique case (state_q)
            ST_SWALLOW: mod_ctl = 1'b1;
            ST_FAULT:   cfg_err = 1'b1;
            default: ;
        endcase
    end

    // R5: the divided pulse lasts a single clock
    a_r5_fp_one_wide: assert property (@(posedge clk) disable iff (!rst_n)
        fp |=> !fp);

    // R4: the alternate modulus is only in use while swallows remain
    a_r4_swallow_left: assert property (@(posedge clk) disable iff (!rst_n)
        mod_ctl |-> (sw_cnt != '0));

    // R2: while running, the main counter is never empty
    a_r2_main_live: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (mn_cnt != '0));

    // R8: a running divider always works from legal settings
    a_r8_running_legal: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (act_n_q >= NLO && N_W'(act_a_q) < act_n_q));

    // R7: no pulse is produced one clock after the fault state is observed
    a_r7_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err && $past(cfg_err)) |-> !fp);

endmodule

// File: tb/tb_swallow_divider.sv
module tb_swallow_divider;

    localparam int PS  = 4;
    localparam int PL  = 8;
    localparam int AW  = 3;
    localparam int NW  = 5;
    localparam int NMN = 4;

    typedef struct {
        int    len;
        int    mods;
        string req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mod_sel = 1'b0;
    logic [AW-1:0] swallow_a = '0;
    logic [NW-1:0] main_n = '0;
    logic          load = 1'b0;
    logic          fp, mod_ctl, cfg_err;

    int   checks = 0;
    int   errors = 0;
    exp_t exp_q[$];
    int   rs_req = 0;
    int   rs_seen = 0;
    bit   done = 1'b0;
    string quiet_req = "R1";

    always #2 clk = ~clk;

    swallow_divider #(
        .P_SMALL(PS), .P_LARGE(PL), .A_W(AW), .N_W(NW), .N_MIN(NMN)
    ) dut (
        .clk(clk), .rst_n(rst_n), .mod_sel(mod_sel), .swallow_a(swallow_a),
        .main_n(main_n), .load(load), .fp(fp), .mod_ctl(mod_ctl), .cfg_err(cfg_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // driver side
    task automatic push(input int sel, input int a, input int n, input int cnt,
                        input string req);
        int p;
        p = sel ? PS : PL;
        for (int i = 0; i < cnt; i++) begin
            exp_t e;
            e.len  = p * n + a;
            e.mods = a * (p + 1);
            e.req  = req;
            exp_q.push_back(e);
        end
    endtask

    task automatic do_load(input int sel, input int a, input int n);
        @(posedge clk); #1;
        mod_sel   = sel[0];
        swallow_a = AW'(a);
        main_n    = NW'(n);
        load      = 1'b1;
        @(posedge clk); #1;
        load      = 1'b0;
    endtask

    task automatic restart(input int sel, input int a, input int n, input int cnt,
                           input string req);
        push(sel, a, n, cnt, req);
        rs_req++;
        do_load(sel, a, n);
    endtask

    task automatic wait_last;
        while (exp_q.size() > 1) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic drain;
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    // monitor side
    int cyc = 0;
    int mods = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (fp) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, quiet_req, "unexpected fp pulse", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(cyc == e.len, e.req, "output period", cyc, e.len);
                    check(mods == e.mods, e.req, "mod_ctl high clocks", mods, e.mods);
                end
                cyc  = 0;
                mods = 0;
            end else if (rs_req != rs_seen && !load) begin
                rs_seen = rs_req;
                cyc  = 0;
                mods = 0;
            end
            cyc++;
            if (mod_ctl) mods++;
            if (fp) begin
                @(negedge clk);
                if (rst_n) begin
                    check(!fp, "R5", "fp width beyond one clock", int'(fp), 0);
                    cyc++;
                    if (mod_ctl) mods++;
                end
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(fp == 1'b0, "R1", "fp after reset", int'(fp), 0);
        check(mod_ctl == 1'b0, "R1", "mod_ctl after reset", int'(mod_ctl), 0);
        check(cfg_err == 1'b0, "R1", "cfg_err after reset", int'(cfg_err), 0);
        repeat (40) @(negedge clk);
        check(fp == 1'b0 && exp_q.size() == 0, "R1", "idle fp", int'(fp), 0);

        // R2: small modulus, start from idle
        quiet_req = "R2";
        restart(1, 3, 5, 3, "R2");
        // R6: the fourth cycle is in progress when new settings arrive
        push(1, 3, 5, 1, "R6");
        wait_last();
        // R3: large modulus applied at the boundary
        do_load(0, 2, 6);
        push(0, 2, 6, 2, "R3");
        wait_last();
        // R4: A of zero keeps mod_ctl low
        do_load(1, 0, 4);
        push(1, 0, 4, 2, "R4");
        wait_last();
        // R4: largest A and N
        do_load(0, 7, 31);
        push(0, 7, 31, 1, "R4");
        wait_last();
        // R10: two loads in one cycle, the second wins
        do_load(0, 1, 20);
        repeat (2) @(negedge clk);
        do_load(1, 2, 7);
        push(1, 2, 7, 2, "R10");
        wait_last();

        // R8: A equal to N takes over at the boundary
        quiet_req = "R8";
        do_load(1, 6, 6);
        drain();
        @(negedge clk);
        check(cfg_err == 1'b1, "R8", "cfg_err for A>=N", int'(cfg_err), 1);
        check(mod_ctl == 1'b0, "R8", "mod_ctl in fault", int'(mod_ctl), 0);
        repeat (300) @(negedge clk);
        check(cfg_err == 1'b1, "R8", "cfg_err held", int'(cfg_err), 1);

        // R9: legal load restarts from fault
        quiet_req = "R9";
        restart(1, 1, 4, 2, "R9");
        @(negedge clk);
        check(cfg_err == 1'b0, "R9", "cfg_err after recovery", int'(cfg_err), 0);
        wait_last();

        // R7: N below the minimum
        quiet_req = "R7";
        do_load(1, 0, 3);
        drain();
        @(negedge clk);
        check(cfg_err == 1'b1, "R7", "cfg_err for small N", int'(cfg_err), 1);
        repeat (200) @(negedge clk);
        check(fp == 1'b0 && mod_ctl == 1'b0, "R7", "outputs quiet in fault",
              int'(fp) + int'(mod_ctl), 0);
        // R7: an illegal load in fault keeps the fault
        do_load(0, 2, 2);
        @(negedge clk);
        check(cfg_err == 1'b1, "R7", "cfg_err after illegal reload", int'(cfg_err), 1);
        repeat (50) @(negedge clk);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule